// File: doc/BRIEF.md
# Four-Port Quasi-Bidirectional Pin Block

This block models four byte-wide general-purpose pin groups. Every pin has a storage flop. When the flop holds 0, the pin is pulled hard low. When it holds 1, the pin is released to a weak high. In that released state something outside the chip can still pull the pin low, so the same pin can serve as an input. Each pin is a wired-AND net. The pin level is high only when the internal drive is released and no outside device pulls it low. Outside pull-downs arrive on `ext_low_n`, and the resolved levels leave on `pin_level`.

Software writes a whole group at once or changes one pin of a group. A combinational read returns the resolved pin levels of any group.

Three groups have a second role:
- Group 3 merges three peripheral outputs into its drive: serial transmit, write strobe and read strobe.
- Group 3 hands five pin levels to peripherals: serial receive, two interrupt lines and two counter inputs.
- While `bus_mode` is high, group 0 carries the low address/data byte of an external memory bus, and group 2 carries the high address byte.

Group 1 is plain I/O and has no second role.

Top module: `qbio_ports`

## Requirements
- R1: While `rst_n` is low, and after it rises until the next write, every storage flop of all four groups holds 1. All pins then equal `ext_low_n`.
- R2: A pin whose effective internal drive is 0 reads 0, whatever `ext_low_n` does.
- R3: A byte write (`wr_en`=1, `wr_single`=0) loads `wr_data` into the flops of group `wr_sel` at the clock edge. The other three groups keep their contents.
- R4: A single-pin write (`wr_en`=1, `wr_single`=1) sets flop bit `wr_bit` of group `wr_sel` to `wr_data[0]`. The other seven bits of that group and all other groups are unchanged.
- R5: A pin whose effective drive is 1 follows the outside net: it reads 0 exactly when its `ext_low_n` bit is 0. Pin p of group g is bit 8g+p of `pin_level` and `ext_low_n`.
- R6: `rd_data` equals the 8 pin levels of group `rd_sel` in the same cycle.
- R7: The drive of group 3 is the flop value ANDed with the second-role value of each bit. Bit 1 takes `alt_txd`, bit 6 takes `alt_wr_n`, bit 7 takes `alt_rd_n`, and all other bits take 1.
- R8: `alt_rxd` is group-3 pin 0, `alt_int_n[1:0]` are pins 3:2, and `alt_cnt[1:0]` are pins 5:4. Each of them reads 0 while the matching flop holds 0.
- R9: Group 1 drive equals its flop contents. `bus_mode` and all second-role inputs have no effect on it.
- R10: With `bus_mode`=1, group 0 drive is `bus_lo_out` when `bus_lo_oe`=1 and all ones otherwise, and group 2 drive is `bus_hi_out`. The flops of groups 0 and 2 are ignored but keep their contents. `bus_lo_in` always equals the group-0 pin levels.
- R11: With `bus_mode`=0, `bus_lo_oe`, `bus_lo_out` and `bus_hi_out` have no effect on any pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sets all flops to 1 |
| wr_en | input | 1 | Write strobe for the flops |
| wr_sel | input | 2 | Group addressed by a write |
| wr_single | input | 1 | 1 = single-pin write, 0 = byte write |
| wr_bit | input | 3 | Pin index for a single-pin write |
| wr_data | input | 8 | Byte to write; bit 0 is the value for a single-pin write |
| rd_sel | input | 2 | Group returned on `rd_data` |
| rd_data | output | 8 | Resolved pin levels of the selected group |
| ext_low_n | input | 32 | Outside pull-downs, 0 = pulled low, 8 bits per group |
| pin_level | output | 32 | Resolved pin levels, 8 bits per group |
| bus_mode | input | 1 | External memory bus owns groups 0 and 2 |
| bus_lo_oe | input | 1 | Bus drives group 0 (address or write data) |
| bus_lo_out | input | 8 | Low address / write data byte |
| bus_hi_out | input | 8 | High address byte |
| bus_lo_in | output | 8 | Group-0 pin levels returned to the bus (read data) |
| alt_txd | input | 1 | Serial transmit level for group-3 pin 1 |
| alt_wr_n | input | 1 | Write strobe level for group-3 pin 6 |
| alt_rd_n | input | 1 | Read strobe level for group-3 pin 7 |
| alt_rxd | output | 1 | Serial receive level from group-3 pin 0 |
| alt_int_n | output | 2 | Interrupt line levels from group-3 pins 3:2 |
| alt_cnt | output | 2 | Counter input levels from group-3 pins 5:4 |

## Verification
The flop assertions assume that a write names one group and, for a single-pin write, one bit index within range. The bench guarantees this because `wr_sel` and `wr_bit` are exactly as wide as their ranges.

The pin assertions assume that `ext_low_n` and the second-role inputs are steady around the clock edge. The bench changes every input only at the falling edge.

Most outside pull-downs are left released, so that the flop values and the bus values are what the pins show. Bus mode, the strobes and the write kinds are randomised over many cycles. Directed cases cover reset, a pin held low against an outside high, and a bus takeover and release.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
  localparam int QB_PW    = 8;
  localparam int QB_NP    = 4;
  localparam int QB_IW    = $clog2(QB_PW);
  localparam int QB_GRP_LO  = 0;
  localparam int QB_GRP_IO  = 1;
  localparam int QB_GRP_HI  = 2;
  localparam int QB_GRP_ALT = 3;

  typedef enum logic [1:0] {
    DRV_LATCH = 2'd0,
    DRV_MERGE = 2'd1,
    DRV_BUS   = 2'd2
  } drv_kind_e;

  // new flop contents after a byte or single-pin write
  function automatic logic [QB_PW-1:0] qb_merge_write(
    input logic [QB_PW-1:0] old_q,
    input logic             single,
    input logic [QB_IW-1:0] idx,
    input logic [QB_PW-1:0] data);
    logic [QB_PW-1:0] nq;
    nq = old_q;
    if (single) nq[idx] = data[0];
    else        nq = data;
    return nq;
  endfunction

  // second-role drive for group 3; released bits are 1
  function automatic logic [QB_PW-1:0] qb_alt_drive(
    input logic txd, input logic wr_n, input logic rd_n);
    logic [QB_PW-1:0] a;
    a    = '1;
    a[1] = txd;
    a[6] = wr_n;
    a[7] = rd_n;
    return a;
  endfunction
endpackage

// File: rtl/qbio_latch.sv
module qbio_latch
  import qbio_pkg::*;
#(
  parameter int W  = QB_PW,
  localparam int IW = $clog2(W)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          single,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  q
);
  logic [W-1:0] q_next;
  logic [W-1:0] keep_mask;

  always_comb begin
    q_next = q;
    if (we) begin
      if (single) q_next[idx] = din[0];
      else        q_next = din;
    end
  end

  always_comb begin
    keep_mask = '1;
    keep_mask[idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= q_next;
  end

  AST_LATCH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> q == {W{1'b1}}); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R3
  AST_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !single) |=> q == $past(din)); // R3
  AST_BIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (we && single) |=> (((q ^ $past(q)) & $past(keep_mask)) == '0)
                       && (q[$past(idx)] == $past(din[0]))); // R4
endmodule

// File: rtl/qbio_drive.sv
module qbio_drive
  import qbio_pkg::*;
#(
  parameter int W = QB_PW
)(
  input  drv_kind_e     kind,
  input  logic [W-1:0]  latch_q,
  input  logic [W-1:0]  alt_val,
  input  logic [W-1:0]  bus_val,
  output logic [W-1:0]  drive
);
  always_comb begin
    unique case (kind)
      DRV_MERGE: drive = latch_q & alt_val;
      DRV_BUS:   drive = bus_val;
      default:   drive = latch_q;
    endcase
  end
endmodule

// File: rtl/qbio_pad.sv
module qbio_pad #(
  parameter int N = 32
)(
  input  logic [N-1:0] drive,
  input  logic [N-1:0] ext_low_n,
  output logic [N-1:0] level
);
  // wired-AND net with weak pull-up: any pull-down wins
  assign level = drive & ext_low_n;
endmodule

// File: rtl/qbio_ports.sv
module qbio_ports
  import qbio_pkg::*;
#(
  parameter int PW = QB_PW,
  localparam int NP = QB_NP,
  localparam int IW = $clog2(PW),
  localparam int SW = $clog2(NP),
  localparam int TW = PW * NP
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic          wr_single,
  input  logic [IW-1:0] wr_bit,
  input  logic [PW-1:0] wr_data,
  input  logic [SW-1:0] rd_sel,
  output logic [PW-1:0] rd_data,
  input  logic [TW-1:0] ext_low_n,
  output logic [TW-1:0] pin_level,
  input  logic          bus_mode,
  input  logic          bus_lo_oe,
  input  logic [PW-1:0] bus_lo_out,
  input  logic [PW-1:0] bus_hi_out,
  output logic [PW-1:0] bus_lo_in,
  input  logic          alt_txd,
  input  logic          alt_wr_n,
  input  logic          alt_rd_n,
  output logic          alt_rxd,
  output logic [1:0]    alt_int_n,
  output logic [1:0]    alt_cnt
);
  logic [PW-1:0] lat_q   [NP];
  logic [PW-1:0] grp_drv [NP];
  logic [TW-1:0] drive_flat;
  logic [PW-1:0] alt_merge;
  logic [PW-1:0] bus_lo_val;

  assign alt_merge  = qb_alt_drive(alt_txd, alt_wr_n, alt_rd_n);
  assign bus_lo_val = bus_lo_oe ? bus_lo_out : {PW{1'b1}};

  for (genvar g = 0; g < NP; g++) begin : g_grp
    logic          sel_we;
    drv_kind_e     kind;
    logic [PW-1:0] alt_v;
    logic [PW-1:0] bus_v;

    assign sel_we = wr_en && (wr_sel == SW'(g));

    qbio_latch #(.W(PW)) u_latch (
      .clk(clk), .rst_n(rst_n), .we(sel_we), .single(wr_single),
      .idx(wr_bit), .din(wr_data), .q(lat_q[g]));

    if (g == QB_GRP_ALT) begin : g_alt
      assign kind  = DRV_MERGE;
      assign alt_v = alt_merge;
      assign bus_v = '1;
    end else if (g == QB_GRP_LO) begin : g_lo
      assign kind  = bus_mode ? DRV_BUS : DRV_LATCH;
      assign alt_v = '1;
      assign bus_v = bus_lo_val;
    end else if (g == QB_GRP_HI) begin : g_hi
      assign kind  = bus_mode ? DRV_BUS : DRV_LATCH;
      assign alt_v = '1;
      assign bus_v = bus_hi_out;
    end else begin : g_io
      assign kind  = DRV_LATCH;
      assign alt_v = '1;
      assign bus_v = '1;
    end

    qbio_drive #(.W(PW)) u_drive (
      .kind(kind), .latch_q(lat_q[g]), .alt_val(alt_v),
      .bus_val(bus_v), .drive(grp_drv[g]));

    assign drive_flat[g*PW +: PW] = grp_drv[g];
  end

  qbio_pad #(.N(TW)) u_pad (
    .drive(drive_flat), .ext_low_n(ext_low_n), .level(pin_level));

  // named views of pin groups for reads and assertions
  logic [PW-1:0] pins_lo, pins_io, pins_hi, pins_alt;
  assign pins_lo  = pin_level[QB_GRP_LO*PW  +: PW];
  assign pins_io  = pin_level[QB_GRP_IO*PW  +: PW];
  assign pins_hi  = pin_level[QB_GRP_HI*PW  +: PW];
  assign pins_alt = pin_level[QB_GRP_ALT*PW +: PW];

  assign rd_data   = pin_level[rd_sel*PW +: PW];
  assign bus_lo_in = pins_lo;
  assign alt_rxd   = pins_alt[0];
  assign alt_int_n = pins_alt[3:2];
  assign alt_cnt   = pins_alt[5:4];

  AST_IO_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (~lat_q[QB_GRP_IO] & pins_io) == '0); // R2
  AST_ALT_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (~lat_q[QB_GRP_ALT] & pins_alt) == '0); // R7
  AST_RXD_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    alt_rxd |-> lat_q[QB_GRP_ALT][0]); // R8
  AST_BUS_HI_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |-> (pins_hi & ~bus_hi_out) == '0); // R10
  AST_LATCH_OWNS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mode |-> (pins_lo & ~lat_q[QB_GRP_LO]) == '0); // R11
endmodule

// File: tb/tb_qbio_ports.sv
`timescale 1ns/100ps
module tb_qbio_ports;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_single;
  logic [1:0]  wr_sel, rd_sel;
  logic [2:0]  wr_bit;
  logic [7:0]  wr_data, rd_data;
  logic [31:0] ext_low_n, pin_level;
  logic        bus_mode, bus_lo_oe;
  logic [7:0]  bus_lo_out, bus_hi_out, bus_lo_in;
  logic        alt_txd, alt_wr_n, alt_rd_n, alt_rxd;
  logic [1:0]  alt_int_n, alt_cnt;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] m_lat [4];

  always #2.5 clk = ~clk;

  qbio_ports dut (.*);

  // expected drive of one pin, stated per requirement
  function automatic logic pin_drive(int g, int b);
    logic d;
    d = m_lat[g][b];
    if (g == 3) begin                                  // R7
      if (b == 1) d = d & alt_txd;
      if (b == 6) d = d & alt_wr_n;
      if (b == 7) d = d & alt_rd_n;
    end
    if (bus_mode && g == 0) d = bus_lo_oe ? bus_lo_out[b] : 1'b1;  // R10
    if (bus_mode && g == 2) d = bus_hi_out[b];                      // R10
    return d;
  endfunction

  function automatic logic [31:0] exp_pins();
    logic [31:0] e;
    for (int g = 0; g < 4; g++)
      for (int b = 0; b < 8; b++)
        e[g*8+b] = pin_drive(g, b) ? ext_low_n[g*8+b] : 1'b0;  // R2 R5
    return e;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [31:0] e;
    e = exp_pins();
    chk({tag, " pins"}, pin_level, e);
    chk("R6 read", {24'd0, rd_data}, {24'd0, e[rd_sel*8 +: 8]});
    chk("R10 bus_lo_in", {24'd0, bus_lo_in}, {24'd0, e[7:0]});
    chk("R8 alt inputs", {27'd0, alt_cnt, alt_int_n, alt_rxd},
        {27'd0, e[29:28], e[27:26], e[24]});
  endtask

  task automatic model_edge();
    if (wr_en) begin
      if (wr_single) m_lat[wr_sel][wr_bit] = wr_data[0];
      else           m_lat[wr_sel] = wr_data;
    end
  endtask

  // one cycle: inputs applied at the falling edge, checked, then clocked
  task automatic cyc(string tag);
    #1 check_all(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_single = 0; wr_sel = 0; wr_bit = 0; wr_data = 0;
    rd_sel = 0; ext_low_n = '1; bus_mode = 0; bus_lo_oe = 0;
    bus_lo_out = 0; bus_hi_out = 0; alt_txd = 1; alt_wr_n = 1; alt_rd_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    idle_inputs();
    rst_n = 0;
    for (int g = 0; g < 4; g++) m_lat[g] = 8'hFF;
    @(negedge clk); @(negedge clk);
    chk("R1 reset pins", pin_level, 32'hFFFF_FFFF);
    ext_low_n = 32'h5A5A_A5A5;
    #1 chk("R1 reset follows ext", pin_level, 32'h5A5A_A5A5);
    rst_n = 1;
    ext_low_n = '1;
    @(negedge clk);
    cyc("R1 after release");

    // R2: byte write of zero to group 1 holds pins low
    wr_en = 1; wr_sel = 1; wr_data = 8'h00;
    cyc("R3 write group1");
    wr_en = 0;
    cyc("R2 group1 low");
    chk("R2 held low", {24'd0, pin_level[15:8]}, 32'd0);

    // R4: single-pin writes
    wr_en = 1; wr_single = 1; wr_sel = 1; wr_bit = 3'd5; wr_data = 8'h01;
    cyc("R4 set bit5");
    wr_bit = 3'd0; wr_data = 8'hFE;
    cyc("R4 clear bit0");
    wr_en = 0; wr_single = 0;
    cyc("R4 result");
    chk("R4 group1 value", {24'd0, pin_level[15:8]}, 32'h20);

    // R5: released pin pulled low from outside
    ext_low_n = 32'hFFFF_DFFF;
    cyc("R5 ext pull");
    ext_low_n = '1;

    // R7 / R8: strobes and alt inputs with group-3 bit 0 cleared
    wr_en = 1; wr_single = 1; wr_sel = 3; wr_bit = 0; wr_data = 0;
    cyc("R8 clear rxd flop");
    wr_en = 0; wr_single = 0;
    alt_txd = 0; alt_rd_n = 0;
    cyc("R7 strobes");
    chk("R8 rxd reads 0", {31'd0, alt_rxd}, 32'd0);

    // R10 / R9: bus takeover keeps flops
    wr_en = 1; wr_sel = 0; wr_data = 8'h3C;
    cyc("R3 write group0");
    wr_sel = 2; wr_data = 8'h81;
    cyc("R3 write group2");
    wr_en = 0; bus_mode = 1; bus_lo_oe = 1; bus_lo_out = 8'hA5; bus_hi_out = 8'h7E;
    cyc("R10 bus drive");
    bus_lo_oe = 0; ext_low_n = 32'hFFFF_FF0F;
    cyc("R10 bus read");
    chk("R10 read data", {24'd0, bus_lo_in}, 32'h0F);
    bus_mode = 0; ext_low_n = '1;
    cyc("R11 bus released");
    chk("R10 flops kept", {16'd0, pin_level[23:16], pin_level[7:0]}, 32'h813C);
    chk("R9 group1 untouched", {24'd0, pin_level[15:8]}, 32'h20);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      wr_en      = ($urandom % 3) == 0;
      wr_single  = $urandom % 2;
      wr_sel     = 2'($urandom);
      wr_bit     = 3'($urandom);
      wr_data    = 8'($urandom);
      rd_sel     = 2'($urandom);
      ext_low_n  = ($urandom % 4 == 0) ? ($urandom | $urandom) : '1;
      bus_mode   = ($urandom % 3) == 0;
      bus_lo_oe  = $urandom % 2;
      bus_lo_out = 8'($urandom);
      bus_hi_out = 8'($urandom);
      alt_txd    = $urandom % 2;
      alt_wr_n   = $urandom % 2;
      alt_rd_n   = $urandom % 2;
      cyc("R3 R4 R5 R7 R9 R10 R11 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule